// File: doc/BRIEF.md
# TDM Time Slot Assigner

This block sits between two serial time-division-multiplexed (TDM) links and four serial controller ports. Each link has a receive direction and a transmit direction. Each of the four half-duplex directions has its own frame sync and its own bit-clock qualifier, and each runs its own slot walker. After a frame sync, the walker steps through that direction's region of a host-programmed routing table. Each table entry covers a span of bits. It names the controller port that owns those bits, and it carries a strobe mask that drives up to four strobe outputs while the span lasts. The strobe outputs do not depend on where the data goes.

The routing table has two banks. The host can rewrite one bank while frames run from the other. A direction changes banks only at its own next frame sync, so a frame in progress is never cut over part-way. A controller port can receive slots from one link and transmit slots on the other at the same time.

The four bit clocks arrive as clock-enable pulses that are synchronous to `clk_i`. Forming those pulses from the pad clocks is outside this block.

Top module: `tdm_tsa`

## Requirements
- R1: While `rst_ni` is low, and after it rises until the first tick, every output is 0. All four walkers start idle.
- R2: The table has two banks of 64 entries of 16 bits. The host writes an entry at the rising clock edge when `host_we_i` is high. Direction d owns entries d*16 to d*16+15 of a bank, with d = 0 for link A receive, 1 for link A transmit, 2 for link B receive and 3 for link B transmit.
- R3: Entry encoding:
  - bit 15 is the last-entry flag;
  - bits 14:12 are the destination, where 1 to 4 select ports 0 to 3 and 0, 5, 6 or 7 select no port;
  - bits 11:8 are the strobe mask;
  - bit 5 selects the span unit;
  - bits 4:0 are the count minus one.
  
  The span is count bits, or 8 times count bits when bit 5 is set. Bits 7:6 have no effect.
- R4: A tick (`bclk_en_i[d]` high) that arrives with `fsync_i[d]` high handles its bit with entry 0 of the region. This restarts the walker even in the middle of a frame. A sync that arrives without a tick is ignored.
- R5: The walker moves on after the final bit of an entry's span. If that entry has the last flag set, or is the 16th entry of the region, the walker goes idle. While idle, ticks route no bit, give strobe mask 0 and disable the transmit line until the next sync tick.
- R6: On a receive tick, the bit on `rxd_i[link]` goes to the destination port. In the next cycle `port_rx_valid_o` pulses high for one cycle with the bit on `port_rx_bit_o`. A receive bit with no destination is discarded. The bit output is 0 whenever valid is low. When both links deliver a bit to the same port in the same cycle, link A wins.
- R7: On a transmit tick, `txd_o[link]` and `txoe_o[link]` are registered and held until that direction's next tick. With a destination, `txoe_o` is 1, `txd_o` is the value of `port_tx_bit_i` for that port at the tick, and `port_tx_pop_o` for that port pulses for one cycle. With no destination, or when idle, both `txoe_o` and `txd_o` are 0.
- R8: Each direction holds the strobe mask of the entry used at its latest tick until its next tick. `strobe_o` is the OR of the four held masks. The mask applies whatever the destination is.
- R9: `bank_sel_i` is sampled at a direction's sync tick and is used for that whole frame. Writes to the other bank do not affect the frame.
- R10: The four directions run independently. A port may receive on one link and transmit on the other in the same frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Table write strobe |
| host_bank_i | input | 1 | Bank to write |
| host_addr_i | input | 6 | Entry address within the bank |
| host_wdata_i | input | 16 | Entry value |
| bank_sel_i | input | 1 | Bank that frames use from their next sync |
| bclk_en_i | input | 4 | Bit tick per direction (A rx, A tx, B rx, B tx) |
| fsync_i | input | 4 | Frame sync per direction |
| rxd_i | input | 2 | Receive serial data, links A and B |
| txd_o | output | 2 | Transmit serial data, links A and B |
| txoe_o | output | 2 | Transmit output enable, links A and B |
| port_rx_valid_o | output | 4 | Receive bit valid per controller port |
| port_rx_bit_o | output | 4 | Receive bit per controller port |
| port_tx_bit_i | input | 4 | Transmit bit offered by each controller port |
| port_tx_pop_o | output | 4 | Transmit bit consumed, per port |
| strobe_o | output | 4 | Strobe outputs |

## Verification
The bench builds the block with its default parameters: two links, four ports, four strobes and 16-entry regions. With 16-entry regions, a single frame can walk off the end of a region and reach the wrap-to-idle rule. The two links tick at different rates, with frame lengths of 9 to 22 ticks, so frames that end in idle time, frames that run back to back and frames cut short by an early sync all occur. Link A and link B receive ticks line up every sixth cycle, which brings the port collision rule into play. The bench also switches banks while frames are running, adds reserved-bit noise and sync pulses that arrive without a tick, and compares every port, line and strobe on every cycle against an arithmetic model of the table.

// File: rtl/tsa_pkg.sv
package tsa_pkg;
  localparam int ENTRY_W = 16;
  localparam int DEST_W  = 3;
  localparam int MASK_W  = 4;
  localparam int CNT_W   = 5;
  localparam int SPAN_W  = CNT_W + 3;

  typedef struct packed {
    logic              last;
    logic [DEST_W-1:0] dest;
    logic [MASK_W-1:0] mask;
    logic [1:0]        rsvd;
    logic              byte_unit;
    logic [CNT_W-1:0]  cnt_m1;
  } entry_t;

  function automatic logic [SPAN_W-1:0] span_end(entry_t e);
    return e.byte_unit ? {e.cnt_m1, 3'b111} : SPAN_W'(e.cnt_m1);
  endfunction
endpackage

// File: rtl/tsa_route_ram.sv
module tsa_route_ram #(
  parameter int DEPTH  = 64,
  parameter int N_RD   = 4,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic                                  clk_i,
  input  logic                                  we_i,
  input  logic                                  wbank_i,
  input  logic [ADDR_W-1:0]                     waddr_i,
  input  logic [tsa_pkg::ENTRY_W-1:0]           wdata_i,
  input  logic [N_RD-1:0]                       rbank_i,
  input  logic [N_RD-1:0][ADDR_W-1:0]           raddr_i,
  output logic [N_RD-1:0][tsa_pkg::ENTRY_W-1:0] rdata_o
);
  logic [tsa_pkg::ENTRY_W-1:0] mem0 [DEPTH];
  logic [tsa_pkg::ENTRY_W-1:0] mem1 [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i && !wbank_i) mem0[waddr_i] <= wdata_i;
    if (we_i &&  wbank_i) mem1[waddr_i] <= wdata_i;
  end

  for (genvar r = 0; r < N_RD; r++) begin : g_rd
    assign rdata_o[r] = rbank_i[r] ? mem1[raddr_i[r]] : mem0[raddr_i[r]];
  end
endmodule

// File: rtl/tsa_walker.sv
module tsa_walker #(
  parameter int REGION_BASE  = 0,
  parameter int REGION_DEPTH = 16,
  parameter int ADDR_W       = 6,
  localparam int IDX_W       = $clog2(REGION_DEPTH)
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         tick_i,
  input  logic                         sync_i,
  input  logic                         bank_sel_i,
  output logic                         rd_bank_o,
  output logic [ADDR_W-1:0]            rd_addr_o,
  input  logic [tsa_pkg::ENTRY_W-1:0]  rd_data_i,
  output logic                         hit_o,
  output logic [tsa_pkg::DEST_W-1:0]   dest_o,
  output logic [tsa_pkg::MASK_W-1:0]   strb_o
);
  import tsa_pkg::*;

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(REGION_BASE);
  localparam logic [IDX_W-1:0]  TOP  = IDX_W'(REGION_DEPTH - 1);

  logic              act_q, bank_q;
  logic [IDX_W-1:0]  idx_q, use_idx;
  logic [SPAN_W-1:0] cnt_q, use_cnt;
  logic [MASK_W-1:0] strb_q;
  entry_t            ent;
  logic              at_end, final_ent;

  assign ent       = entry_t'(rd_data_i);
  assign use_idx   = sync_i ? '0 : idx_q;
  assign use_cnt   = sync_i ? '0 : cnt_q;
  assign rd_bank_o = sync_i ? bank_sel_i : bank_q;
  assign rd_addr_o = BASE + ADDR_W'(use_idx);
  assign hit_o     = tick_i && (sync_i || act_q);
  assign dest_o    = ent.dest;
  assign at_end    = use_cnt == span_end(ent);
  assign final_ent = ent.last || (use_idx == TOP);
  assign strb_o    = strb_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q  <= 1'b0;
      bank_q <= 1'b0;
      idx_q  <= '0;
      cnt_q  <= '0;
      strb_q <= '0;
    end else if (tick_i) begin
      strb_q <= hit_o ? ent.mask : '0;
      if (hit_o) begin
        bank_q <= rd_bank_o;
        if (at_end) begin
          cnt_q <= '0;
          if (final_ent) begin
            act_q <= 1'b0;
            idx_q <= '0;
          end else begin
            act_q <= 1'b1;
            idx_q <= use_idx + 1'b1;
          end
        end else begin
          act_q <= 1'b1;
          idx_q <= use_idx;
          cnt_q <= use_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/tsa_steer.sv
module tsa_steer #(
  parameter int N_IF   = 2,
  parameter int N_PORT = 4,
  localparam int N_DIR = 2 * N_IF
) (
  input  logic                                  clk_i,
  input  logic                                  rst_ni,
  input  logic [N_DIR-1:0]                      tick_i,
  input  logic [N_DIR-1:0]                      hit_i,
  input  logic [N_DIR-1:0][tsa_pkg::DEST_W-1:0] dest_i,
  input  logic [N_IF-1:0]                       rxd_i,
  input  logic [N_PORT-1:0]                     port_tx_bit_i,
  output logic [N_IF-1:0]                       txd_o,
  output logic [N_IF-1:0]                       txoe_o,
  output logic [N_PORT-1:0]                     rx_valid_o,
  output logic [N_PORT-1:0]                     rx_bit_o,
  output logic [N_PORT-1:0]                     tx_pop_o
);
  import tsa_pkg::*;

  logic [N_PORT-1:0] rxv_d, rxb_d, pop_d;
  logic [N_IF-1:0]   txd_d, oe_d;

  always_comb begin
    rxv_d = '0;
    rxb_d = '0;
    pop_d = '0;
    for (int p = 0; p < N_PORT; p++) begin
      // link A visited last so it wins a collision
      for (int i = N_IF - 1; i >= 0; i--) begin
        if (hit_i[2*i] && dest_i[2*i] == DEST_W'(p + 1)) begin
          rxv_d[p] = 1'b1;
          rxb_d[p] = rxd_i[i];
        end
      end
    end
    for (int i = 0; i < N_IF; i++) begin
      txd_d[i] = 1'b0;
      oe_d[i]  = 1'b0;
      for (int p = 0; p < N_PORT; p++) begin
        if (hit_i[2*i+1] && dest_i[2*i+1] == DEST_W'(p + 1)) begin
          txd_d[i] = port_tx_bit_i[p];
          oe_d[i]  = 1'b1;
          pop_d[p] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_valid_o <= '0;
      rx_bit_o   <= '0;
      tx_pop_o   <= '0;
      txd_o      <= '0;
      txoe_o     <= '0;
    end else begin
      rx_valid_o <= rxv_d;
      rx_bit_o   <= rxb_d;
      tx_pop_o   <= pop_d;
      for (int i = 0; i < N_IF; i++) begin
        if (tick_i[2*i+1]) begin
          txd_o[i]  <= txd_d[i];
          txoe_o[i] <= oe_d[i];
        end
      end
    end
  end
endmodule

// File: rtl/tdm_tsa.sv
module tdm_tsa #(
  parameter int N_IF         = 2,
  parameter int N_PORT       = 4,
  parameter int N_STRB       = 4,
  parameter int REGION_DEPTH = 16,
  localparam int N_DIR       = 2 * N_IF,
  localparam int DEPTH       = N_DIR * REGION_DEPTH,
  localparam int ADDR_W      = $clog2(DEPTH)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        host_we_i,
  input  logic                        host_bank_i,
  input  logic [ADDR_W-1:0]           host_addr_i,
  input  logic [tsa_pkg::ENTRY_W-1:0] host_wdata_i,
  input  logic                        bank_sel_i,
  input  logic [N_DIR-1:0]            bclk_en_i,
  input  logic [N_DIR-1:0]            fsync_i,
  input  logic [N_IF-1:0]             rxd_i,
  output logic [N_IF-1:0]             txd_o,
  output logic [N_IF-1:0]             txoe_o,
  output logic [N_PORT-1:0]           port_rx_valid_o,
  output logic [N_PORT-1:0]           port_rx_bit_o,
  input  logic [N_PORT-1:0]           port_tx_bit_i,
  output logic [N_PORT-1:0]           port_tx_pop_o,
  output logic [N_STRB-1:0]           strobe_o
);
  import tsa_pkg::*;

  logic [N_DIR-1:0]               rd_bank;
  logic [N_DIR-1:0][ADDR_W-1:0]   rd_addr;
  logic [N_DIR-1:0][ENTRY_W-1:0]  rd_data;
  logic [N_DIR-1:0]               hit;
  logic [N_DIR-1:0][DEST_W-1:0]   dest;
  logic [N_DIR-1:0][MASK_W-1:0]   strb;

  tsa_route_ram #(.DEPTH(DEPTH), .N_RD(N_DIR), .ADDR_W(ADDR_W)) u_ram (
    .clk_i   (clk_i),
    .we_i    (host_we_i),
    .wbank_i (host_bank_i),
    .waddr_i (host_addr_i),
    .wdata_i (host_wdata_i),
    .rbank_i (rd_bank),
    .raddr_i (rd_addr),
    .rdata_o (rd_data)
  );

  for (genvar d = 0; d < N_DIR; d++) begin : g_dir
    tsa_walker #(
      .REGION_BASE  (d * REGION_DEPTH),
      .REGION_DEPTH (REGION_DEPTH),
      .ADDR_W       (ADDR_W)
    ) u_walk (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_i     (bclk_en_i[d]),
      .sync_i     (fsync_i[d]),
      .bank_sel_i (bank_sel_i),
      .rd_bank_o  (rd_bank[d]),
      .rd_addr_o  (rd_addr[d]),
      .rd_data_i  (rd_data[d]),
      .hit_o      (hit[d]),
      .dest_o     (dest[d]),
      .strb_o     (strb[d])
    );
  end

  tsa_steer #(.N_IF(N_IF), .N_PORT(N_PORT)) u_steer (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .tick_i        (bclk_en_i),
    .hit_i         (hit),
    .dest_i        (dest),
    .rxd_i         (rxd_i),
    .port_tx_bit_i (port_tx_bit_i),
    .txd_o         (txd_o),
    .txoe_o        (txoe_o),
    .rx_valid_o    (port_rx_valid_o),
    .rx_bit_o      (port_rx_bit_o),
    .tx_pop_o      (port_tx_pop_o)
  );

  always_comb begin
    strobe_o = '0;
    for (int d = 0; d < N_DIR; d++) strobe_o |= N_STRB'(strb[d]);
  end
endmodule

// File: rtl/tdm_tsa_chk.sv
module tdm_tsa_chk #(
  parameter int N_IF   = 2,
  parameter int N_PORT = 4,
  parameter int N_STRB = 4
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [2*N_IF-1:0]   bclk_en_i,
  input logic [N_IF-1:0]     txd_o,
  input logic [N_IF-1:0]     txoe_o,
  input logic [N_PORT-1:0]   port_rx_valid_o,
  input logic [N_PORT-1:0]   port_rx_bit_o,
  input logic [N_PORT-1:0]   port_tx_pop_o,
  input logic [N_STRB-1:0]   strobe_o
);
  logic [N_IF-1:0] rx_ticks;
  for (genvar i = 0; i < N_IF; i++) begin : g_rt
    assign rx_ticks[i] = bclk_en_i[2*i];
  end

  a_r6_rx_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_rx_valid_o) |-> $past(|rx_ticks));

  a_r6_rx_bit_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (port_rx_bit_o & ~port_rx_valid_o) == '0);

  a_r7_pop_needs_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|port_tx_pop_o) |-> (|txoe_o));

  a_r8_strobe_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bclk_en_i == '0) |=> $stable(strobe_o));

  for (genvar i = 0; i < N_IF; i++) begin : g_tx
    a_r7_line_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bclk_en_i[2*i+1] |=> ($stable(txoe_o[i]) && $stable(txd_o[i])));
    a_r7_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !txoe_o[i] |-> !txd_o[i]);
  end
endmodule

bind tdm_tsa tdm_tsa_chk #(.N_IF(N_IF), .N_PORT(N_PORT), .N_STRB(N_STRB)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .bclk_en_i       (bclk_en_i),
  .txd_o           (txd_o),
  .txoe_o          (txoe_o),
  .port_rx_valid_o (port_rx_valid_o),
  .port_rx_bit_o   (port_rx_bit_o),
  .port_tx_pop_o   (port_tx_pop_o),
  .strobe_o        (strobe_o)
);

// File: tb/tdm_tsa_tb.sv
module tdm_tsa_tb;
  localparam int CYC = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        host_we_i = 1'b0, host_bank_i = 1'b0;
  logic [5:0]  host_addr_i = '0;
  logic [15:0] host_wdata_i = '0;
  logic        bank_sel_i = 1'b0;
  logic [3:0]  bclk_en_i = '0, fsync_i = '0;
  logic [1:0]  rxd_i = '0;
  logic [1:0]  txd_o, txoe_o;
  logic [3:0]  port_rx_valid_o, port_rx_bit_o, port_tx_bit_i = '0, port_tx_pop_o, strobe_o;

  always #(CYC/2) clk_i = ~clk_i;

  tdm_tsa u_dut (.*);

  int errs = 0, checks = 0;
  bit done = 0;
  string ph = "R1 reset";

  logic [15:0] tbl [2][64];
  bit          m_act [4];
  int          m_idx [4], m_bit [4];
  logic        m_bank [4];
  logic [3:0]  strb_d [4];
  logic [3:0]  e_rxv, e_rxb, e_pop;
  logic [1:0]  e_txd, e_oe;
  int          cyc = 0;
  int          tcnt [4];
  int          flen [4] = '{20, 22, 12, 9};

  function automatic logic [15:0] ent(bit last, int dst, logic [3:0] m, bit bu, int c, logic [1:0] rs = 2'b00);
    return {last, 3'(dst), m, rs, bu, 5'(c)};
  endfunction

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s [%s] cyc=%0d actual=%0h expected=%0h", req, ph, cyc, act, exp);
    end
  endtask

  task automatic model(logic [3:0] en, logic [3:0] sy, logic [1:0] rxd, logic [3:0] ptx, logic bsel);
    e_rxv = '0; e_rxb = '0; e_pop = '0;
    for (int d = 3; d >= 0; d--) begin
      if (en[d]) begin
        if (sy[d] || m_act[d]) begin
          int i = sy[d] ? 0 : m_idx[d];
          int b = sy[d] ? 0 : m_bit[d];
          logic bk = sy[d] ? bsel : m_bank[d];
          logic [15:0] e = tbl[bk][d*16 + i];
          int dst = int'(e[14:12]);
          int span = e[5] ? (int'(e[4:0]) + 1) * 8 : int'(e[4:0]) + 1;
          strb_d[d] = e[11:8];
          if (d % 2 == 0) begin
            if (dst >= 1 && dst <= 4) begin e_rxv[dst-1] = 1'b1; e_rxb[dst-1] = rxd[d/2]; end
          end else begin
            if (dst >= 1 && dst <= 4) begin
              e_txd[d/2] = ptx[dst-1]; e_oe[d/2] = 1'b1; e_pop[dst-1] = 1'b1;
            end else begin
              e_txd[d/2] = 1'b0; e_oe[d/2] = 1'b0;
            end
          end
          m_bank[d] = bk;
          if (b + 1 == span) begin
            m_bit[d] = 0;
            if (e[15] || i == 15) begin m_act[d] = 0; m_idx[d] = 0; end
            else begin m_act[d] = 1; m_idx[d] = i + 1; end
          end else begin
            m_act[d] = 1; m_idx[d] = i; m_bit[d] = b + 1;
          end
        end else begin
          strb_d[d] = '0;
          if (d % 2 == 1) begin e_txd[d/2] = 1'b0; e_oe[d/2] = 1'b0; end
        end
      end
    end
  endtask

  task automatic compare();
    logic [3:0] es = strb_d[0] | strb_d[1] | strb_d[2] | strb_d[3];
    chk({port_rx_valid_o, port_rx_bit_o} == {e_rxv, e_rxb}, "R6", {port_rx_valid_o, port_rx_bit_o}, {e_rxv, e_rxb});
    chk({txoe_o, txd_o} == {e_oe, e_txd}, "R7", {txoe_o, txd_o}, {e_oe, e_txd});
    chk(port_tx_pop_o == e_pop, "R7 pop", port_tx_pop_o, e_pop);
    chk(strobe_o == es, "R8", strobe_o, es);
  endtask

  // one cycle: drive at negedge, model, then sample after the edge
  task automatic step(logic [3:0] en, logic [3:0] sy, bit we = 0, bit wb = 0, int wa = 0, logic [15:0] wd = '0);
    @(negedge clk_i);
    bclk_en_i = en; fsync_i = sy;
    rxd_i = 2'($urandom); port_tx_bit_i = 4'($urandom);
    host_we_i = we; host_bank_i = wb; host_addr_i = 6'(wa); host_wdata_i = wd;
    model(en, sy, rxd_i, port_tx_bit_i, bank_sel_i);
    if (we) tbl[wb][wa] = wd;
    @(posedge clk_i); #1;
    compare();
    cyc++;
  endtask

  task automatic wr(bit bk, int a, logic [15:0] d);
    step(4'b0, 4'b0, 1, bk, a, d);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) begin
      logic [3:0] en, sy;
      en[0] = (cyc % 2 == 0); en[1] = en[0];
      en[2] = (cyc % 3 == 0); en[3] = (cyc % 3 == 1);
      for (int d = 0; d < 4; d++) begin
        if (en[d]) begin
          sy[d] = (tcnt[d] % flen[d] == 0);
          tcnt[d]++;
        end else begin
          sy[d] = ($urandom % 5 == 0); // R4: sync without tick must be ignored
        end
      end
      step(en, sy);
    end
  endtask

  initial begin
    for (int b = 0; b < 2; b++) for (int a = 0; a < 64; a++) tbl[b][a] = ent(1, 0, 4'h0, 0, 0);
    for (int d = 0; d < 4; d++) begin
      m_act[d] = 0; m_idx[d] = 0; m_bit[d] = 0; m_bank[d] = 0; strb_d[d] = '0; tcnt[d] = 0;
    end
    e_rxv = '0; e_rxb = '0; e_pop = '0; e_txd = '0; e_oe = '0;
    repeat (3) @(posedge clk_i);
    #1;
    compare(); // R1 outputs zero in reset
    @(negedge clk_i); rst_ni = 1'b1;
    // fill both banks fully so no walker ever reads an unwritten word
    for (int b = 0; b < 2; b++) for (int a = 0; a < 64; a++) wr(b[0], a, ent(1, 0, 4'h0, 0, 0));
    ph = "R2 R3 R5 R10 bank0";
    wr(0, 0,  ent(0, 1, 4'b0001, 0, 2));
    wr(0, 1,  ent(0, 0, 4'b0010, 1, 0));
    wr(0, 2,  ent(1, 3, 4'b0000, 0, 4));
    wr(0, 16, ent(0, 2, 4'b0000, 0, 2));
    wr(0, 17, ent(0, 0, 4'b0100, 0, 1));
    wr(0, 18, ent(1, 1, 4'b1000, 1, 1, 2'b11)); // R3 reserved bits set
    wr(0, 32, ent(0, 2, 4'b0000, 0, 3));
    wr(0, 33, ent(1, 4, 4'b1000, 0, 4));
    wr(0, 48, ent(0, 1, 4'b0001, 0, 6)); // R10 port 0 rx on A, tx on B
    wr(0, 49, ent(1, 0, 4'b0100, 0, 1));
    // bank1: dest 6 discard, 16-entry wrap, early sync, collisions on port 3
    wr(1, 0,  ent(0, 6, 4'b0011, 0, 3));
    wr(1, 1,  ent(1, 4, 4'b0000, 1, 0));
    for (int k = 0; k < 16; k++) wr(1, 16 + k, ent(0, (k % 5), 4'(k), 0, 0));
    wr(1, 32, ent(1, 4, 4'b0110, 0, 19, 2'b01));
    wr(1, 48, ent(0, 3, 4'b1001, 0, 1));
    wr(1, 49, ent(1, 7, 4'b0010, 0, 2));
    run(400);
    ph = "R9 bank switch mid-frame";
    bank_sel_i = 1'b1;
    run(100);
    ph = "R4 R5 early sync and wrap on bank1";
    run(300);
    ph = "R9 rewrite idle bank while running";
    wr(0, 0,  ent(1, 2, 4'b0101, 1, 1));
    wr(0, 16, ent(1, 4, 4'b0011, 0, 9));
    wr(0, 32, ent(0, 1, 4'b0000, 0, 0));
    wr(0, 33, ent(1, 3, 4'b1100, 0, 1));
    run(150);
    bank_sel_i = 1'b0;
    run(400);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(CYC * 200000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog [%s] actual=hung expected=finish", ph);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule